// File: doc/BRIEF.md
# Serial Attenuation Control Front End

This block is the digital control side of a two-channel audio attenuator. A host sends 16-bit command words over three wires: a serial clock, an active-low shift enable (the load line) and a data line. While the load line is low, each rising edge of the serial clock moves one data bit into a shift register, most significant bit first. The bit pushed out of the far end of that register is driven on a data-out pin. Several devices can therefore be chained on one data line and share one load line.

When the load line goes back high, the word now in the register is decoded. The upper byte picks the channel and the lower byte is a step code. Codes in the low range give half-dB steps, codes in the middle range give whole-dB steps above 48 dB, and the top codes mute the channel. The written channel updates its attenuation, held in half-dB units, and its mute flag, and raises a one-cycle strobe.

All three serial inputs are synchronised into a faster system clock, and both the clock edges and the load edges are detected in that domain.

Top module: `serial_atten_ctrl`

## Requirements
- R1: After reset, both channels read level 0 and unmuted, no update strobe is high, and data-out is 0.
- R2: While the load line is low, each rising edge of the serial clock shifts the data-in bit into a 16-bit register, most significant bit first.
- R3: Serial clock edges while the load line is high leave the shift register unchanged. This can be seen at data-out during the next transfer, which still shows the earlier word.
- R4: Data-out carries the register's most significant bit. Just before the k-th rising edge of a transfer, it equals the bit that went in 16 edges earlier.
- R5: A rising edge of the load line commits the last 16 bits shifted. Upper byte 0x00 writes channel 0 and upper byte 0x01 writes channel 1.
- R6: A committed word whose upper byte is neither 0x00 nor 0x01 changes no channel and raises no strobe.
- R7: Step codes 0 to 95 set the level to the code value, in half-dB units, and clear mute.
- R8: Step codes 96 to 126 set the level to 2·code − 96 half-dB units, which is 48 dB plus one dB per code step, and clear mute. An unmuted level never exceeds 156.
- R9: Step codes 127 to 255 set mute and leave the stored level unchanged.
- R10: Each accepted commit raises the written channel's update strobe for exactly one system clock cycle, in the same cycle the new value appears. At most one strobe is high at a time.
- R11: A commit to one channel leaves the other channel's level, mute flag and strobe untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial interface clock |
| ser_load_i | input | 1 | Shift enable when low; its rising edge commits the word |
| ser_din_i | input | 1 | Serial data in, MSB first |
| ser_dout_o | output | 1 | Bit displaced from the shift register, for chaining |
| lvl_o | output | 2x8 | Per-channel attenuation in half-dB units |
| mute_o | output | 2 | Per-channel mute flag |
| upd_o | output | 2 | Per-channel one-cycle update strobe |

## Verification
Every one of the 256 step codes is sent to channel 0, and every third code to channel 1. This separates the fine segment, the coarse segment and the mute segment, and puts the segment joins at 95/96 and 126/127 under test. Words with out-of-range channel bytes are sent to show that they are dropped. A 32-bit transfer under a single low load window shows that data-out repeats the first word and that only the last word takes effect. Serial clock pulses with the load line high are followed by a transfer whose data-out must still show the earlier word, which proves those pulses were ignored.

// File: rtl/atten_pkg.sv
package atten_pkg;

  localparam int NUM_CH      = 2;
  localparam int CH_IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_W       = 8;
  localparam int CODE_W      = 8;
  localparam int WORD_W      = SEL_W + CODE_W;
  localparam int LVL_W       = 8;
  localparam int FINE_LAST   = 95;
  localparam int COARSE_LAST = 126;

  typedef struct packed {
    logic                valid;
    logic [CH_IDX_W-1:0] ch;
    logic                mute;
    logic [LVL_W-1:0]    lvl;
  } atten_cmd_t;

  // Step code to half-dB units: fine segment is 1:1, coarse segment doubles.
  function automatic logic [LVL_W-1:0] code_to_level(input logic [CODE_W-1:0] code);
    logic [CODE_W:0] dbl;
    dbl = {code, 1'b0};
    if (int'(code) <= FINE_LAST)
      return LVL_W'(code);
    else
      return LVL_W'(dbl - (CODE_W+1)'(FINE_LAST + 1));
  endfunction

  function automatic logic code_is_mute(input logic [CODE_W-1:0] code);
    return int'(code) > COARSE_LAST;
  endfunction

endpackage

// File: rtl/atten_sync_edge.sv
module atten_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] word_o,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign word_o = sr_q;
  assign msb_o  = sr_q[W-1];
endmodule

// File: rtl/atten_decoder.sv
module atten_decoder
  import atten_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output atten_cmd_t        cmd_o
);
  logic [SEL_W-1:0]  sel;
  logic [CODE_W-1:0] code;

  assign sel  = word_i[WORD_W-1 -: SEL_W];
  assign code = word_i[CODE_W-1:0];

  always_comb begin
    cmd_o.valid = (sel < SEL_W'(NUM_CH));
    cmd_o.ch    = sel[CH_IDX_W-1:0];
    cmd_o.mute  = code_is_mute(code);
    cmd_o.lvl   = code_to_level(code);
  end
endmodule

// File: rtl/atten_chan_regs.sv
module atten_chan_regs
  import atten_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  atten_cmd_t       cmd_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             mute_o,
  output logic             upd_o
);
  logic hit;
  assign hit = commit_i & cmd_i.valid & (cmd_i.ch == CH_IDX_W'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o  <= '0;
      mute_o <= 1'b0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= hit;
      if (hit) begin
        if (cmd_i.mute) begin
          mute_o <= 1'b1;
        end else begin
          mute_o <= 1'b0;
          lvl_o  <= cmd_i.lvl;
        end
      end
    end
  end
endmodule

// File: rtl/serial_atten_ctrl.sv
module serial_atten_ctrl
  import atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_clk_i,
  input  logic                         ser_load_i,
  input  logic                         ser_din_i,
  output logic                         ser_dout_o,
  output logic [NUM_CH-1:0][LVL_W-1:0] lvl_o,
  output logic [NUM_CH-1:0]            mute_o,
  output logic [NUM_CH-1:0]            upd_o
);
  // Named internal events, visible to the bound checker.
  logic              sclk_s, sclk_rise;
  logic              load_s, commit_w;
  logic              din_s,  din_rise_unused;
  logic              shift_w;
  logic [WORD_W-1:0] shreg_w;
  atten_cmd_t        cmd_w;

  atten_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .async_i(ser_clk_i), .level_o(sclk_s), .rise_o(sclk_rise));

  atten_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
    .clk(clk), .rst_n(rst_n), .async_i(ser_load_i), .level_o(load_s), .rise_o(commit_w));

  atten_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .async_i(ser_din_i), .level_o(din_s), .rise_o(din_rise_unused));

  assign shift_w = sclk_rise & ~load_s;

  atten_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_w), .din_i(din_s),
    .word_o(shreg_w), .msb_o(ser_dout_o));

  atten_decoder u_dec (.word_i(shreg_w), .cmd_o(cmd_w));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    atten_chan_regs #(.IDX(g)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit_i(commit_w), .cmd_i(cmd_w),
      .lvl_o(lvl_o[g]), .mute_o(mute_o[g]), .upd_o(upd_o[g]));
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, sclk_s, din_rise_unused};
endmodule

// File: rtl/serial_atten_ctrl_chk.sv
module serial_atten_ctrl_chk
  import atten_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         load_s,
  input logic                         din_s,
  input logic                         shift_w,
  input logic                         commit_w,
  input logic [WORD_W-1:0]            shreg_w,
  input logic [NUM_CH-1:0][LVL_W-1:0] lvl_o,
  input logic [NUM_CH-1:0]            mute_o,
  input logic [NUM_CH-1:0]            upd_o
);
  localparam logic [LVL_W-1:0] LVL_CEIL = code_to_level(CODE_W'(COARSE_LAST));

  AST_NO_SHIFT_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> $stable(shreg_w)); // R3
  AST_SHIFT_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_w |=> shreg_w[0] == $past(din_s)); // R2
  AST_COMMIT_ON_LOAD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> (load_s && !$past(load_s))); // R5
  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_o)); // R10
  AST_UPD_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |-> $past(commit_w)); // R10

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    AST_HOLD_WITHOUT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o[g] |-> ($stable(lvl_o[g]) && $stable(mute_o[g]))); // R11
    AST_MUTE_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o[g] && mute_o[g]) |-> $stable(lvl_o[g])); // R9
    AST_LVL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_o[g] |-> (lvl_o[g] <= LVL_CEIL)); // R8
  end
endmodule

bind serial_atten_ctrl serial_atten_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_s(load_s), .din_s(din_s), .shift_w(shift_w),
  .commit_w(commit_w), .shreg_w(shreg_w), .lvl_o(lvl_o), .mute_o(mute_o), .upd_o(upd_o));

// File: tb/serial_atten_ctrl_bench.sv
module serial_atten_ctrl_bench;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_load = 1'b1, ser_din = 1'b0;
  logic ser_dout;
  logic [1:0][7:0] lvl;
  logic [1:0] mute, upd;

  serial_atten_ctrl u_serial_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_load_i(ser_load),
    .ser_din_i(ser_din), .ser_dout_o(ser_dout), .lvl_o(lvl), .mute_o(mute), .upd_o(upd));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int exp_lvl [2];
  bit exp_mute[2];

  logic cnt_clr = 1'b0;
  int upd_cnt[2];
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (cnt_clr) upd_cnt[c] <= 0;
      else if (upd[c]) upd_cnt[c] <= upd_cnt[c] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift one bit; report data-out as seen just before the rising edge.
  task automatic shift_bit(input logic b, output logic seen);
    ser_din = b;
    wait_sys(HALF);
    seen = ser_dout;
    ser_clk = 1'b1;
    wait_sys(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic clear_counts();
    cnt_clr = 1'b1;
    wait_sys(1);
    cnt_clr = 1'b0;
  endtask

  // Model of the decode, written from the requirement text.
  task automatic model_apply(input int sel, input int code);
    if (sel > 1) return;
    if (code >= 127) exp_mute[sel] = 1'b1;
    else begin
      exp_mute[sel] = 1'b0;
      exp_lvl[sel]  = (code < 96) ? code : 2 * (48 + (code - 96));
    end
  endtask

  task automatic check_state(input int sel, input int code);
    string rq;
    rq = (code < 96) ? "R7" : (code < 127) ? "R8" : "R9";
    for (int c = 0; c < 2; c++) begin
      string r;
      r = (sel == c) ? rq : ((sel > 1) ? "R6" : "R11");
      chk(lvl[c] == exp_lvl[c], r, lvl[c], exp_lvl[c]);
      chk(mute[c] == exp_mute[c], r, mute[c], exp_mute[c]);
      chk(upd_cnt[c] == ((sel == c) ? 1 : 0), (sel == c) ? "R10" : r,
          upd_cnt[c], (sel == c) ? 1 : 0);
    end
  endtask

  task automatic commit_and_check(input int sel, input int code);
    wait_sys(HALF);
    ser_load = 1'b1;
    wait_sys(12);
    model_apply(sel, code);
    check_state(sel, code);
  endtask

  // Full word under its own load window (R2, R5).
  task automatic send_word(input int sel, input int code);
    logic [15:0] w;
    logic seen;
    w = {8'(sel), 8'(code)};
    clear_counts();
    ser_load = 1'b0;
    wait_sys(HALF);
    for (int i = 15; i >= 0; i--) shift_bit(w[i], seen);
    commit_and_check(sel, code);
  endtask

  initial begin
    logic seen;
    logic [15:0] wa, wb, wprev;
    exp_lvl  = '{0, 0};
    exp_mute = '{0, 0};
    wait_sys(3);
    rst_n = 1'b1;
    wait_sys(3);
    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      chk(lvl[c] == 0, "R1", lvl[c], 0);
      chk(mute[c] == 0, "R1", mute[c], 0);
      chk(upd[c] == 0, "R1", upd[c], 0);
    end
    chk(ser_dout == 0, "R1", ser_dout, 0);

    // Sweep: every code on channel 0, every third code on channel 1 (R7 R8 R9)
    for (int code = 0; code < 256; code++) send_word(0, code);
    for (int code = 0; code < 256; code += 3) send_word(1, code);
    // Bring both to known unmuted levels
    send_word(0, 40);
    send_word(1, 110);

    // R6: channel bytes outside the valid set
    send_word(2, 10);
    send_word(8'h80, 0);
    send_word(8'hFF, 200);

    // R3: serial clock pulses with load high; then the next transfer shows the old word
    wprev = {8'hFF, 8'd200};
    ser_din = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_sys(HALF); ser_clk = 1'b1; wait_sys(HALF); ser_clk = 1'b0;
    end
    wa = {8'h00, 8'd77};
    clear_counts();
    ser_load = 1'b0;
    wait_sys(HALF);
    for (int i = 15; i >= 0; i--) begin
      shift_bit(wa[i], seen);
      chk(seen == wprev[i], "R3", seen, wprev[i]);
    end
    commit_and_check(0, 77);

    // R4 and R5: 32 bits in one load window; data-out repeats the first word,
    // only the last word is committed
    wa = {8'h00, 8'd10};
    wb = {8'h01, 8'd100};
    clear_counts();
    ser_load = 1'b0;
    wait_sys(HALF);
    for (int i = 15; i >= 0; i--) shift_bit(wa[i], seen);
    for (int i = 15; i >= 0; i--) begin
      shift_bit(wb[i], seen);
      chk(seen == wa[i], "R4", seen, wa[i]);
    end
    commit_and_check(1, 100);
    chk(lvl[0] == 77, "R5", lvl[0], 77);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule